// File: doc/BRIEF.md
# Saturating Bit Counter for Error-Rate Testing

This block tallies the data bits that an error-rate tester receives once its pattern checker has locked. Each cycle that carries a bit-clock enable while the sync flag is held raises the tally by one. The tally never wraps. At all ones it parks, and a sticky flag records that full scale was reached.

Software resets the tally by driving a clear control bit from 0 to 1. Only that rising transition acts. A bit left high or low does nothing more. The tally is read through a byte-wide port with a synchronous address. Byte k of the count sits at address BASE_ADDR + k, so the least significant byte has the lowest address. The counter width is a parameter and must be a multiple of 8.

Top module: `bert_bitcount`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0 and `ovf_flag` becomes 0, so every byte register then reads 00h.
- R2: At an edge where `bit_en` and `sync_ok` are both 1, no clear occurs and the count is below all ones, the count rises by exactly 1.
- R3: At an edge where `bit_en` or `sync_ok` is 0 and no clear occurs, the count keeps its value.
- R4: A clear occurs at the first edge at which `clr_ctl` is sampled 1 after being sampled 0 at the previous edge, or after reset. That edge sets the count to 0 and `ovf_flag` to 0. Further edges with `clr_ctl` held at 1, or held at 0, clear nothing.
- R5: When a clear and a countable bit fall on the same edge, the count becomes 0.
- R6: Once the count is all ones (2^CNT_W - 1), it stays all ones until a clear or reset, whatever `bit_en` and `sync_ok` do.
- R7: `ovf_flag` goes to 1 at the same edge at which the count becomes all ones. It then stays 1 until a clear or reset.
- R8: Byte k of the count (bits 8k+7..8k) is read at address BASE_ADDR + k, for k from 0 to CNT_W/8 - 1. With the defaults (CNT_W = 32, BASE_ADDR = E3h), E3h holds bits 7..0 and E6h holds bits 31..24. `rd_addr` is registered at one edge. `rd_data` shows the byte selected by that registered address at the next edge.
- R9: An address that maps to no count byte reads 00h, with the same latency as R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One received data bit this cycle |
| sync_ok | input | 1 | Pattern synchronization is held |
| clr_ctl | input | 1 | Clear control bit; a rising transition clears the count |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky full-scale status |

## Verification
The bench runs a 16-bit configuration, which is small enough to reach full scale in about 65,000 cycles.

- **Full scale.** It samples `ovf_flag` one bit before all ones and again at all ones. A flag raised one edge late or early would show there. It then keeps counting past full scale, which exposes a counter that wraps to zero.
- **Clear control.** It holds `clr_ctl` high over many counting cycles. A level-sensitive clear would pin the count at zero. It also lands a clear on a counted bit, which catches a count that wins that race.
- **Address map.** The whole 8-bit address space is swept with a known count in place. A swapped byte order, an off-by-one base address, or stale data outside the window would each give a wrong byte.

// File: rtl/bert_bc_pkg.sv
package bert_bc_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Per-cycle command to the counter core
    typedef struct packed {
        logic wipe;   // clear request (edge of control bit)
        logic step;   // countable bit this cycle
    } cnt_cmd_t;

    // Counter core state
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FULL = 2'b10
    } cnt_phase_t;

    function automatic int unsigned byte_count(input int unsigned width);
        return width / BYTE_W;
    endfunction

    function automatic cnt_phase_t phase_of(input logic at_max, input logic any);
        if (at_max)   return ST_FULL;
        else if (any) return ST_RUN;
        else          return ST_IDLE;
    endfunction

endpackage

// File: rtl/bert_clr_edge.sv
module bert_clr_edge (
    input  logic clk,
    input  logic rst,
    input  logic ctl_in,
    output logic rise
);

    logic ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= 1'b0;
        else     ctl_q <= ctl_in;
    end

    assign rise = ctl_in & ~ctl_q;

    // R4: a clear request lasts one cycle only, however long the bit is held
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter
    import bert_bc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] count,
    output logic             full_seen
);

    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             full_q, full_d;
    cnt_phase_t       phase;

    assign phase = phase_of(cnt_q == MAX_VAL, |cnt_q);

    always_comb begin
        cnt_d  = cnt_q;
        full_d = full_q;
        if (cmd.wipe) begin
            cnt_d  = '0;
            full_d = 1'b0;
        end else if (cmd.step && phase != ST_FULL) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_d == MAX_VAL) full_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            full_q <= full_d;
        end
    end

    assign count     = cnt_q;
    assign full_seen = full_q;

    // R2: one step per counted bit below full scale
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (!cmd.wipe && cmd.step && cnt_q != MAX_VAL) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: no bit, no change
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!cmd.wipe && !cmd.step) |=> $stable(cnt_q));

    // R4 / R5: a clear zeroes the count and the flag, even with a bit present
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.wipe |=> (cnt_q == '0 && !full_q));

    // R6: no wrap at full scale
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAX_VAL && !cmd.wipe) |=> (cnt_q == MAX_VAL));

    // R7: flag is sticky and accompanies full scale
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (full_q && !cmd.wipe) |=> full_q);

    a_r7_flag_at_max: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAX_VAL) |-> full_q);

endmodule

// File: rtl/bert_byte_readport.sv
module bert_byte_readport
    import bert_bc_pkg::*;
#(
    parameter int              CNT_W     = 32,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  value,
    output byte_t             data
);

    localparam int NBYTES = byte_count(CNT_W);

    byte_t             lanes [NBYTES];
    logic [ADDR_W-1:0] addr_q;
    byte_t             sel;
    logic              hit;
    byte_t             data_q;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign lanes[k] = value[k*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int k = 0; k < NBYTES; k++) begin
            if (addr_q == ADDR_W'(int'(BASE_ADDR) + k)) begin
                sel = lanes[k];
                hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr;
            data_q <= sel;
        end
    end

    assign data = data_q;

    // R9: unmapped addresses read zero on the following cycle
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (data_q == '0));

endmodule

// File: rtl/bert_bitcount.sv
module bert_bitcount
    import bert_bc_pkg::*;
#(
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              sync_ok,
    input  logic              clr_ctl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              ovf_flag
);

    logic             clr_rise;
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] count;

    bert_clr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ctl_in (clr_ctl),
        .rise   (clr_rise)
    );

    assign cmd.wipe = clr_rise;
    assign cmd.step = bit_en & sync_ok;

    bert_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .count     (count),
        .full_seen (ovf_flag)
    );

    bert_byte_readport #(
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .addr  (rd_addr),
        .value (count),
        .data  (rd_data)
    );

    // R1: reset leaves the flag low
    a_r1_reset_flag: assert property (@(posedge clk)
        rst |=> !ovf_flag);

    // R3: without sync, no clear edge, the flag cannot rise
    a_r3_no_sync_no_rise: assert property (@(posedge clk) disable iff (rst)
        (!sync_ok && !clr_rise) |=> !$rose(ovf_flag));

endmodule

// File: tb/bert_bitcount_tb.sv
module bert_bitcount_tb;

    localparam int  W    = 16;
    localparam int  NB   = W / 8;
    localparam logic [7:0] BASE = 8'hE3;
    localparam longint MAXV = (longint'(1) << W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, sync_ok = 1'b0, clr_ctl = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int     vecs = 0, errs = 0, cycles = 0;
    longint m_cnt = 0;
    bit     m_ovf = 0, m_prev = 0;

    always #4 clk = ~clk;

    bert_bitcount #(.CNT_W(W), .ADDR_W(8), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sync_ok(sync_ok),
        .clr_ctl(clr_ctl), .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errs++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle, called at a negedge, returns at the next negedge
    task automatic cyc(input bit en, input bit sy, input bit cl);
        bit_en = en; sync_ok = sy; clr_ctl = cl;
        @(negedge clk);
        if (cl && !m_prev) begin
            m_cnt = 0; m_ovf = 0;
        end else if (en && sy && m_cnt != MAXV) begin
            m_cnt++;
            if (m_cnt == MAXV) m_ovf = 1;
        end
        m_prev = cl;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        cyc(0, 0, m_prev);
        cyc(0, 0, m_prev);
        d = rd_data;
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        int off = int'(a) - int'(BASE);
        if (off < 0 || off >= NB) return 8'h00;
        return 8'((m_cnt >> (8 * off)) & 8'hFF);
    endfunction

    task automatic chk_count(input string req);
        logic [7:0] d;
        longint v = 0;
        for (int k = 0; k < NB; k++) begin
            rd(BASE + 8'(k), d);
            v = v | (longint'(d) << (8 * k));
        end
        chk(req, v, m_cnt);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ovf", ovf_flag, 0);
        chk_count("R1 count");

        // R2 / R3: all enable/sync combinations in a pattern
        for (int i = 0; i < 200; i++) cyc(i[0], i[1] | i[3], 0);
        chk_count("R2 R3 mixed pattern");
        for (int i = 0; i < 40; i++) cyc(1, 1, 0);
        chk_count("R2 steady counting");
        for (int i = 0; i < 40; i++) cyc(1, 0, 0);
        chk_count("R3 no sync");
        for (int i = 0; i < 40; i++) cyc(0, 1, 0);
        chk_count("R3 no bit");

        // R4: rising edge clears, held level does not
        cyc(1, 1, 1);
        chk_count("R4 edge clears");
        for (int i = 0; i < 25; i++) cyc(1, 1, 1);
        chk_count("R4 held high no clear");
        chk("R4 held high value", m_cnt, 25);
        for (int i = 0; i < 10; i++) cyc(1, 1, 0);
        chk_count("R4 held low no clear");

        // R5: clear and bit on the same edge
        cyc(1, 1, 1);
        chk_count("R5 clear wins");
        chk("R5 zero", m_cnt, 0);
        cyc(0, 0, 0);

        // R8 / R9: full address sweep with a known count
        for (int i = 0; i < 'h1A5; i++) cyc(1, 1, 0);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            chk((a >= int'(BASE) && a < int'(BASE) + NB) ? "R8 byte map" : "R9 unmapped",
                d, exp_byte(8'(a)));
        end

        // R6 / R7: run to full scale
        while (m_cnt < MAXV - 1) cyc(1, 1, 0);
        chk("R7 flag low below max", ovf_flag, 0);
        cyc(1, 1, 0);
        chk("R7 flag set at max", ovf_flag, 1);
        for (int i = 0; i < 20; i++) cyc(1, 1, 0);
        chk_count("R6 no wrap");
        chk("R6 max value", m_cnt, MAXV);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);
        chk("R7 flag sticky", ovf_flag, 1);
        cyc(0, 0, 1);
        chk("R7 flag cleared", ovf_flag, 0);
        chk_count("R4 clear after full");

        // R1 again: reset mid-count
        for (int i = 0; i < 7; i++) cyc(1, 1, 0);
        rst = 1'b1;
        cyc(0, 0, 0);
        rst = 1'b0;
        m_cnt = 0; m_ovf = 0; m_prev = 0;
        chk("R1 reset flag", ovf_flag, 0);
        chk_count("R1 reset count");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule